// File: doc/BRIEF.md
# I2C Master Single-Event Sequencer

This block is the master side of a two-wire serial bus that performs one bus event per request. The controlling logic issues START, repeated START, STOP, receive-one-byte or send-acknowledge by pulsing a request line. Each request sets an enable bit, and the hardware clears that bit when the event ends. A byte transmission begins when the transmit buffer is written. It shifts out eight bits MSB first and then releases SDA for a ninth clock, on which the addressed device answers.

A bit-rate divider splits every SCL period into four equal quarters of `reload + 1` system clocks each. The divider is held at zero while nothing is in progress. SCL and SDA are open-drain: an output of 1 pulls the line low, and 0 releases it. The block is used the way a polled or interrupt-driven peripheral is. Software waits for `busy` to fall or for the event-complete flag, then issues the next event. A request made while an event is still running, or several requests in the same cycle, is refused and recorded as a write collision.

A companion arbitration monitor reports lost arbitration on `coll_i`. The engine then drops everything and returns to idle with both lines released.

The sequencer has the following states:
- S_IDLE holds the line levels left by the last event.
- S_START runs both START and repeated START.
- S_STOP runs STOP.
- S_TX runs nine bit slots: eight data bits and one acknowledge slot.
- S_RX runs eight bit slots.
- S_ACK runs one bit slot.

The transitions are:
- S_IDLE moves to the state of an accepted request.
- Each busy state returns to S_IDLE at the end of its last quarter.
- Every state returns to S_IDLE on a collision.

Top module: `i2c_event_master`

## Requirements
- R1: After a synchronous reset, SCL and SDA are released (`scl_oe`=0, `sda_oe`=0), `enables` is 0, and `busy`, `evt_irq`, `wcol`, `buf_full`, `rx_ovf` and `ack_stat` are all 0.
- R2: Each bit quarter lasts `reload+1` clocks. START, STOP and acknowledge each take 4*(reload+1) clocks of `busy`, a receive takes 32*(reload+1) and a transmit takes 36*(reload+1). SCL is released for 2*(reload+1) clocks in every bit slot.
- R3: `cmd_start` sets `enables[0]` and `cmd_rstart` sets `enables[1]`. Either one releases SDA, releases SCL, pulls SDA low while SCL is high, and then pulls SCL low. The enable bit clears at the end of the event.
- R4: `cmd_stop` sets `enables[2]`. It pulls SDA low while SCL is low, releases SCL, and then releases SDA while SCL is high. Both lines are left released.
- R5: A buffer write while idle sets `buf_full` and sends the byte MSB first on eight SCL pulses, then releases SDA on a ninth pulse. The SDA level sampled on that ninth pulse becomes `ack_stat` (1 = NACK), and `buf_full` clears at the end.
- R6: `cmd_rcv` sets `enables[3]` and samples SDA on eight SCL pulses, MSB first. At the end the byte appears on `buf_rdata`, `buf_full` sets and `enables[3]` clears. A `buf_rd` pulse clears `buf_full`.
- R7: If a received byte completes while `buf_full` is still 1, `rx_ovf` sets and `buf_rdata` keeps its previous byte.
- R8: `cmd_ack` sets `enables[4]` and produces one SCL pulse during which SDA carries the `ack_val` captured with the request (0 = ACK drives low, 1 = NACK releases).
- R9: A request arriving while `busy` is 1, or two or more requests in the same cycle, set `wcol`. Such a request changes neither `enables` nor the buffer, starts no event and raises no `evt_irq`.
- R10: `evt_irq` sets at the end of every START, repeated START, STOP, transmit, receive and acknowledge event, and it stays set until `irq_clr`.
- R11: `coll_i` aborts the event in progress. It releases both lines, clears `enables`, `buf_full` and the transmit, and returns to idle without setting `evt_irq`. A later START works normally.
- R12: While the engine owns the bus, SDA changes only while SCL is held low, with two exceptions: the START falling edge and the STOP rising edge.
- R13: `busy` is 1 exactly while any enable bit is set or a transmit is running, and `enables` stays 0 during a transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reload | input | RLD_W | Quarter-period reload value: fclk/(4*bit rate) - 1 |
| cmd_start | input | 1 | Request START |
| cmd_rstart | input | 1 | Request repeated START |
| cmd_stop | input | 1 | Request STOP |
| cmd_rcv | input | 1 | Request reception of one byte |
| cmd_ack | input | 1 | Request an acknowledge slot |
| ack_val | input | 1 | Level sent in the acknowledge slot (0 ACK, 1 NACK) |
| buf_wr | input | 1 | Write `buf_wdata` to the buffer and transmit it |
| buf_wdata | input | 8 | Byte to transmit |
| buf_rd | input | 1 | Buffer read strobe, clears `buf_full` |
| irq_clr | input | 1 | Clear `evt_irq` |
| wcol_clr | input | 1 | Clear `wcol` |
| ovf_clr | input | 1 | Clear `rx_ovf` |
| sda_i | input | 1 | Sampled SDA line level |
| coll_i | input | 1 | Lost-arbitration report from the bus monitor |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| enables | output | 5 | Self-clearing enable bits {ack, rcv, stop, rstart, start} |
| busy | output | 1 | An event is in progress |
| evt_irq | output | 1 | Event-complete flag |
| ack_stat | output | 1 | Acknowledge level seen after the last transmit |
| wcol | output | 1 | Write-collision flag |
| buf_full | output | 1 | Buffer holds unread or untransmitted data |
| rx_ovf | output | 1 | Receive overflow flag |
| buf_rdata | output | 8 | Buffer contents |

## Verification
The hardest situation to reach is a refused request that lands in the middle of a running receive. The refusal must leave the running waveform untouched, and the buffer must end up holding the received byte rather than the rejected write. The bench reaches it by starting a receive against a modelled slave that shifts a known pattern on each falling SCL edge. While `busy` is still high, it fires a buffer write and a STOP request. It then checks the collision flag and the enable bits at once, and checks the buffer contents after completion. A receive overflow is produced by leaving the buffer unread across a second receive. Lost arbitration is injected on `coll_i` partway through a transmit.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int BYTE_W = 8;
    localparam int NCMD   = 5;

    // Operation handed from the request decoder to the sequencer.
    typedef enum logic [2:0] {
        OP_NONE,
        OP_START,
        OP_RSTART,
        OP_STOP,
        OP_RCV,
        OP_ACK,
        OP_TX
    } op_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_STOP,
        S_TX,
        S_RX,
        S_ACK
    } state_e;

endpackage

// File: rtl/i2cm_qtick.sv
// Quarter-bit tick generator: one tick every reload+1 clocks while run is high.
module i2cm_qtick #(
    parameter int RLD_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [RLD_W-1:0] reload,
    output logic             tick
);

    logic [RLD_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == reload) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == reload);

    // R2: the counter never passes the reload value while running
    a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        run && $stable(reload) && $past(run) |-> cnt <= reload);

endmodule

// File: rtl/i2cm_seq.sv
// Bus waveform sequencer: produces the SCL/SDA drive for one event at a time.
module i2cm_seq
    import i2cm_pkg::*;
#(
    parameter int RLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RLD_W-1:0]  reload,
    input  logic              go,
    input  op_e               op,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              ack_bit,
    input  logic              abort,
    input  logic              sda_i,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              ack_seen,
    output logic              active,
    output logic              scl_oe,
    output logic              sda_oe
);

    localparam int BITS_W = $clog2(BYTE_W + 1) + 1;
    localparam logic [BITS_W-1:0] TX_LAST = BITS_W'(BYTE_W);
    localparam logic [BITS_W-1:0] RX_LAST = BITS_W'(BYTE_W - 1);

    state_e              state, state_nx;
    logic [1:0]          q;
    logic [BITS_W-1:0]   bitn;
    logic [BITS_W-1:0]   last_bit;
    logic [BYTE_W:0]     sh;
    logic [BYTE_W-1:0]   rx_sh;
    logic                hold_scl_low, hold_sda_low;
    logic                tick, ev_end;

    i2cm_qtick #(.RLD_W(RLD_W)) u_qtick (
        .clk    (clk),
        .rst    (rst),
        .run    (active),
        .reload (reload),
        .tick   (tick)
    );

    assign active   = (state != S_IDLE);
    assign last_bit = (state == S_TX) ? TX_LAST : (state == S_RX) ? RX_LAST : '0;
    assign ev_end   = active && tick && (q == 2'd3) && (bitn == last_bit);
    assign done     = ev_end && !abort;
    assign rx_byte  = rx_sh;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (go) begin
                    unique case (op)
                        OP_START, OP_RSTART: state_nx = S_START;
                        OP_STOP:             state_nx = S_STOP;
                        OP_RCV:              state_nx = S_RX;
                        OP_ACK:              state_nx = S_ACK;
                        OP_TX:               state_nx = S_TX;
                        default:             state_nx = S_IDLE;
                    endcase
                end
            end
            S_START, S_STOP, S_TX, S_RX, S_ACK: begin
                if (ev_end) state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
        if (abort) state_nx = S_IDLE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nx;
    end

    // Quarter, bit and shift datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            q            <= '0;
            bitn         <= '0;
            sh           <= '1;
            rx_sh        <= '0;
            ack_seen     <= 1'b0;
            hold_scl_low <= 1'b0;
            hold_sda_low <= 1'b0;
        end else if (abort) begin
            q            <= '0;
            bitn         <= '0;
            hold_scl_low <= 1'b0;
            hold_sda_low <= 1'b0;
        end else if (!active) begin
            if (go) begin
                q    <= '0;
                bitn <= '0;
                unique case (op)
                    OP_TX:   sh <= {tx_byte, 1'b1};
                    OP_ACK:  sh <= {ack_bit, {BYTE_W{1'b1}}};
                    default: sh <= '1;
                endcase
            end
        end else if (tick) begin
            q <= q + 1'b1;
            if (q == 2'd1) begin
                if (state == S_RX) rx_sh <= {rx_sh[BYTE_W-2:0], sda_i};
                if (state == S_TX && bitn == TX_LAST) ack_seen <= sda_i;
            end
            if (q == 2'd3) begin
                bitn <= bitn + 1'b1;
                sh   <= {sh[BYTE_W-1:0], 1'b1};
                if (bitn == last_bit) begin
                    unique case (state)
                        S_START: begin hold_scl_low <= 1'b1; hold_sda_low <= 1'b1; end
                        S_STOP:  begin hold_scl_low <= 1'b0; hold_sda_low <= 1'b0; end
                        default: begin hold_scl_low <= 1'b1; hold_sda_low <= ~sh[BYTE_W]; end
                    endcase
                end
            end
        end
    end

    // Line drive decode
    always_comb begin
        scl_oe = hold_scl_low;
        sda_oe = hold_sda_low;
        unique case (state)
            S_IDLE: begin
                scl_oe = hold_scl_low;
                sda_oe = hold_sda_low;
            end
            S_START: begin
                unique case (q)
                    2'd0: begin scl_oe = hold_scl_low; sda_oe = 1'b0; end
                    2'd1: begin scl_oe = 1'b0;         sda_oe = 1'b0; end
                    2'd2: begin scl_oe = 1'b0;         sda_oe = 1'b1; end
                    default: begin scl_oe = 1'b1;      sda_oe = 1'b1; end
                endcase
            end
            S_STOP: begin
                unique case (q)
                    2'd0: begin scl_oe = 1'b1; sda_oe = 1'b1; end
                    2'd1, 2'd2: begin scl_oe = 1'b0; sda_oe = 1'b1; end
                    default: begin scl_oe = 1'b0; sda_oe = 1'b0; end
                endcase
            end
            S_TX, S_RX, S_ACK: begin
                scl_oe = (q == 2'd0) || (q == 2'd3);
                sda_oe = ~sh[BYTE_W];
            end
            default: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
        endcase
    end

    // R12: SDA moves only under a held-low SCL, except START/STOP edges and abort
    a_r12_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) && !$past(abort)
        && !((state == S_START && q == 2'd2) || (state == S_STOP && q == 2'd3))
        |-> scl_oe && $past(scl_oe));

    // R3: a START always leaves both lines pulled low
    a_r3_start_leaves_low: assert property (@(posedge clk) disable iff (rst)
        (state == S_START) && done |=> scl_oe && sda_oe);

    // R4: a STOP always leaves both lines released
    a_r4_stop_releases: assert property (@(posedge clk) disable iff (rst)
        (state == S_STOP) && done |=> !scl_oe && !sda_oe);

endmodule

// File: rtl/i2c_event_master.sv
// Request decoder, buffer and flags around the bus sequencer.
module i2c_event_master
    import i2cm_pkg::*;
#(
    parameter int RLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RLD_W-1:0]  reload,
    input  logic              cmd_start,
    input  logic              cmd_rstart,
    input  logic              cmd_stop,
    input  logic              cmd_rcv,
    input  logic              cmd_ack,
    input  logic              ack_val,
    input  logic              buf_wr,
    input  logic [BYTE_W-1:0] buf_wdata,
    input  logic              buf_rd,
    input  logic              irq_clr,
    input  logic              wcol_clr,
    input  logic              ovf_clr,
    input  logic              sda_i,
    input  logic              coll_i,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [NCMD-1:0]   enables,
    output logic              busy,
    output logic              evt_irq,
    output logic              ack_stat,
    output logic              wcol,
    output logic              buf_full,
    output logic              rx_ovf,
    output logic [BYTE_W-1:0] buf_rdata
);

    logic [NCMD-1:0]   en_q;
    logic [NCMD:0]     req;
    logic              tx_act, req_any, multi, accept, reject;
    logic              seq_done, seq_ack, seq_active;
    logic [BYTE_W-1:0] seq_rx, buf_q;
    op_e               op;

    assign req     = {cmd_ack, cmd_rcv, cmd_stop, cmd_rstart, cmd_start, buf_wr};
    assign req_any = |req;
    assign multi   = ($countones(req) > 1);
    assign busy    = (|en_q) || tx_act;
    assign accept  = req_any && !multi && !busy && !coll_i;
    assign reject  = req_any && (multi || busy) && !coll_i;

    always_comb begin
        op = OP_NONE;
        if (buf_wr)          op = OP_TX;
        else if (cmd_start)  op = OP_START;
        else if (cmd_rstart) op = OP_RSTART;
        else if (cmd_stop)   op = OP_STOP;
        else if (cmd_rcv)    op = OP_RCV;
        else if (cmd_ack)    op = OP_ACK;
    end

    i2cm_seq #(.RLD_W(RLD_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .reload   (reload),
        .go       (accept),
        .op       (op),
        .tx_byte  (buf_wdata),
        .ack_bit  (ack_val),
        .abort    (coll_i),
        .sda_i    (sda_i),
        .done     (seq_done),
        .rx_byte  (seq_rx),
        .ack_seen (seq_ack),
        .active   (seq_active),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            tx_act   <= 1'b0;
            evt_irq  <= 1'b0;
            ack_stat <= 1'b0;
            wcol     <= 1'b0;
            buf_full <= 1'b0;
            rx_ovf   <= 1'b0;
            buf_q    <= '0;
        end else begin
            if (irq_clr)  evt_irq  <= 1'b0;
            if (wcol_clr) wcol     <= 1'b0;
            if (ovf_clr)  rx_ovf   <= 1'b0;
            if (buf_rd)   buf_full <= 1'b0;
            if (reject)   wcol     <= 1'b1;
            if (coll_i) begin
                en_q     <= '0;
                tx_act   <= 1'b0;
                buf_full <= 1'b0;
            end else if (accept) begin
                if (buf_wr) begin
                    buf_q    <= buf_wdata;
                    buf_full <= 1'b1;
                    tx_act   <= 1'b1;
                end else begin
                    en_q <= req[NCMD:1];
                end
            end else if (seq_done) begin
                en_q    <= '0;
                tx_act  <= 1'b0;
                evt_irq <= 1'b1;
                if (tx_act) begin
                    buf_full <= 1'b0;
                    ack_stat <= seq_ack;
                end
                if (en_q[3]) begin
                    if (buf_full && !buf_rd) begin
                        rx_ovf <= 1'b1;
                    end else begin
                        buf_q    <= seq_rx;
                        buf_full <= 1'b1;
                    end
                end
            end
        end
    end

    assign enables   = en_q;
    assign buf_rdata = buf_q;

    // R13: the request-side busy view matches the sequencer's activity
    a_r13_busy_tracks_seq: assert property (@(posedge clk) disable iff (rst)
        busy == seq_active);

    // R9: a refused request leaves the enable bits untouched
    a_r9_refused_no_effect: assert property (@(posedge clk) disable iff (rst)
        req_any && busy && !seq_done && !coll_i |=> enables == $past(enables));

    // R10: completion raises the event flag
    a_r10_irq_on_done: assert property (@(posedge clk) disable iff (rst)
        seq_done && !coll_i |=> evt_irq);

    // R11: lost arbitration releases the bus and idles the engine
    a_r11_abort_release: assert property (@(posedge clk) disable iff (rst)
        coll_i |=> !scl_oe && !sda_oe && !busy && !buf_full);

    // R7: overflow keeps the earlier byte
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        seq_done && en_q[3] && buf_full && !buf_rd && !coll_i
        |=> rx_ovf && $stable(buf_rdata));

endmodule

// File: tb/i2c_event_master_tb.sv
module i2c_event_master_tb;

    localparam int RLD = 3;
    localparam int QW  = RLD + 1;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] reload = 8'(RLD);
    logic       cmd_start = 0, cmd_rstart = 0, cmd_stop = 0, cmd_rcv = 0, cmd_ack = 0;
    logic       ack_val = 0, buf_wr = 0, buf_rd = 0;
    logic [7:0] buf_wdata = '0;
    logic       irq_clr = 0, wcol_clr = 0, ovf_clr = 0, coll_i = 0;
    logic       sda_i, scl_oe, sda_oe, busy, evt_irq, ack_stat, wcol, buf_full, rx_ovf;
    logic [4:0] enables;
    logic [7:0] buf_rdata;

    // bus model
    logic       scl_line, sda_line, slv_en = 0, slv_pull;
    logic [8:0] slv_bits = '1;
    int         slv_idx = 0;
    logic [8:0] mon_sh = '0;
    int         mon_cnt = 0, n_start = 0, n_stop = 0, hi_run = 0, last_hi = 0;
    int         n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    assign scl_line = ~scl_oe;
    assign slv_pull = slv_en && (slv_idx < 9) && !slv_bits[8 - slv_idx];
    assign sda_line = ~sda_oe && ~slv_pull;
    assign sda_i    = sda_line;

    i2c_event_master u_dut (
        .clk(clk), .rst(rst), .reload(reload),
        .cmd_start(cmd_start), .cmd_rstart(cmd_rstart), .cmd_stop(cmd_stop),
        .cmd_rcv(cmd_rcv), .cmd_ack(cmd_ack), .ack_val(ack_val),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_rd(buf_rd),
        .irq_clr(irq_clr), .wcol_clr(wcol_clr), .ovf_clr(ovf_clr),
        .sda_i(sda_i), .coll_i(coll_i),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .enables(enables), .busy(busy),
        .evt_irq(evt_irq), .ack_stat(ack_stat), .wcol(wcol), .buf_full(buf_full),
        .rx_ovf(rx_ovf), .buf_rdata(buf_rdata)
    );

    // slave shifts on SCL falling edges
    always @(posedge scl_oe) if (slv_en) slv_idx++;
    // monitor samples SDA on SCL rising edges
    always @(negedge scl_oe) begin mon_sh = {mon_sh[7:0], sda_line}; mon_cnt++; end
    always @(negedge sda_line) if (!scl_oe) n_start++;
    always @(posedge sda_line) if (!scl_oe) n_stop++;
    always @(posedge clk) begin
        if (scl_line) hi_run++;
        else begin
            if (hi_run != 0) last_hi = hi_run;
            hi_run = 0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // req = {ack, rcv, stop, rstart, start, buf_wr}
    task automatic issue(input logic [5:0] req);
        @(negedge clk);
        {cmd_ack, cmd_rcv, cmd_stop, cmd_rstart, cmd_start, buf_wr} = req;
        @(negedge clk);
        {cmd_ack, cmd_rcv, cmd_stop, cmd_rstart, cmd_start, buf_wr} = '0;
    endtask

    task automatic pulse_clr(input logic [2:0] c); // {ovf, wcol, irq}
        @(negedge clk);
        {ovf_clr, wcol_clr, irq_clr} = c;
        @(negedge clk);
        {ovf_clr, wcol_clr, irq_clr} = '0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy && cyc < 5000) begin cyc++; @(negedge clk); end
    endtask

    task automatic arm(input logic [8:0] bits);
        slv_bits = bits; slv_idx = 0; slv_en = 1;
    endtask

    task automatic t_reset;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 scl released", scl_oe, 0);
        check("R1 sda released", sda_oe, 0);
        check("R1 enables", enables, 0);
        check("R1 flags {busy,irq,wcol,full,ovf,ack}",
              {busy, evt_irq, wcol, buf_full, rx_ovf, ack_stat}, 0);
    endtask

    task automatic t_start(input bit rep);
        int cyc, s0;
        s0 = n_start;
        issue(rep ? 6'b000100 : 6'b000010);
        check(rep ? "R3 rstart enable" : "R3 start enable", enables, rep ? 5'b00010 : 5'b00001);
        check("R13 busy during start", busy, 1);
        wait_idle(cyc);
        check("R2 start duration", cyc, 4 * QW);
        check("R3 start edge seen", n_start - s0, 1);
        check("R3 lines held low", {scl_oe, sda_oe}, 2'b11);
        check("R3 enable cleared", enables, 0);
        check("R10 irq after start", evt_irq, 1);
        pulse_clr(3'b001);
    endtask

    task automatic t_tx(input logic [7:0] b, input logic ackb);
        int cyc, s0, p0;
        arm({8'hFF, ackb});
        mon_cnt = 0; s0 = n_start; p0 = n_stop;
        buf_wdata = b;
        issue(6'b000001);
        check("R5 buf_full during tx", buf_full, 1);
        check("R13 busy during tx", busy, 1);
        check("R13 enables zero in tx", enables, 0);
        wait_idle(cyc);
        check("R2 tx duration", cyc, 36 * QW);
        check("R2 scl high time", last_hi, 2 * QW);
        check("R5 nine clocks", mon_cnt, 9);
        check("R5 data msb first", mon_sh[8:1], b);
        check("R5 ack_stat", ack_stat, ackb);
        check("R5 buf_full cleared", buf_full, 0);
        check("R12 no stray start/stop", {n_start - s0, n_stop - p0}, 0);
        check("R10 irq after tx", evt_irq, 1);
        slv_en = 0;
        pulse_clr(3'b001);
    endtask

    task automatic t_rx(input logic [7:0] b, input bit ovf, input logic [7:0] old);
        int cyc;
        arm({b, 1'b1});
        issue(6'b010000);
        check("R6 rcv enable", enables, 5'b01000);
        wait_idle(cyc);
        check("R2 rx duration", cyc, 32 * QW);
        check("R6 rcv enable cleared", enables, 0);
        if (!ovf) begin
            check("R6 received byte", buf_rdata, b);
            check("R6 buf_full set", buf_full, 1);
        end else begin
            check("R7 overflow flag", rx_ovf, 1);
            check("R7 old byte kept", buf_rdata, old);
        end
        check("R10 irq after rx", evt_irq, 1);
        slv_en = 0;
        pulse_clr(3'b001);
    endtask

    task automatic t_read;
        @(negedge clk); buf_rd = 1; @(negedge clk); buf_rd = 0;
        check("R6 read clears buf_full", buf_full, 0);
    endtask

    task automatic t_ack(input logic v);
        int cyc;
        ack_val = v; mon_cnt = 0;
        issue(6'b100000);
        check("R8 ack enable", enables, 5'b10000);
        wait_idle(cyc);
        check("R2 ack duration", cyc, 4 * QW);
        check("R8 one clock", mon_cnt, 1);
        check("R8 sda level", mon_sh[0], v);
        check("R10 irq after ack", evt_irq, 1);
        pulse_clr(3'b001);
    endtask

    task automatic t_stop;
        int cyc, p0;
        p0 = n_stop;
        issue(6'b001000);
        check("R4 stop enable", enables, 5'b00100);
        wait_idle(cyc);
        check("R4 stop edge seen", n_stop - p0, 1);
        check("R4 lines released", {scl_oe, sda_oe}, 2'b00);
        check("R10 irq after stop", evt_irq, 1);
        pulse_clr(3'b001);
    endtask

    task automatic t_wcol_busy;
        int cyc;
        arm({8'hC3, 1'b1});
        issue(6'b010000);
        buf_wdata = 8'h77;
        issue(6'b000001);
        check("R9 wcol on busy write", wcol, 1);
        check("R9 enables unchanged", enables, 5'b01000);
        issue(6'b001000);
        check("R9 stop refused", enables, 5'b01000);
        wait_idle(cyc);
        check("R9 buffer not written", buf_rdata, 8'hC3);
        slv_en = 0;
        pulse_clr(3'b011);
        check("R9 wcol cleared", wcol, 0);
    endtask

    task automatic t_wcol_multi;
        int s0;
        s0 = n_start;
        issue(6'b001010);
        check("R9 wcol on double request", wcol, 1);
        check("R9 nothing started", busy, 0);
        repeat (10) @(negedge clk);
        check("R9 no irq from refusal", evt_irq, 0);
        check("R9 no start edge", n_start - s0, 0);
        pulse_clr(3'b010);
    endtask

    task automatic t_coll;
        arm({8'hFF, 1'b0});
        buf_wdata = 8'h81;
        issue(6'b000001);
        repeat (20) @(negedge clk);
        coll_i = 1;
        @(negedge clk);
        coll_i = 0;
        check("R11 lines released", {scl_oe, sda_oe}, 2'b00);
        check("R11 idle", busy, 0);
        check("R11 buf_full cleared", buf_full, 0);
        check("R11 enables cleared", enables, 0);
        repeat (5) @(negedge clk);
        check("R11 no irq", evt_irq, 0);
        slv_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_start(0);
        t_tx(8'hA5, 1'b0);
        t_tx(8'h3C, 1'b1);
        t_start(1);
        t_tx(8'hA1, 1'b0);
        t_rx(8'h96, 0, 8'h00);
        t_ack(1'b0);
        t_rx(8'h5A, 1, 8'h96);
        t_read();
        pulse_clr(3'b100);
        check("R7 ovf cleared", rx_ovf, 0);
        t_ack(1'b1);
        t_stop();
        t_start(0);
        t_wcol_busy();
        t_read();
        t_stop();
        t_wcol_multi();
        t_start(0);
        t_coll();
        t_start(0);
        t_tx(8'h0F, 1'b0);
        t_stop();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule